// File: doc/BRIEF.md
# Multi-channel trigger peak and sum finder

This block sits at the front of a trigger processor. Each clock it takes one unsigned amplitude sample from each of sixteen photomultiplier channels. From one sample set it finds the largest amplitude and the channel that carries it, adds all amplitudes into one total, and keeps a pulse-time stamp. The stamp marks the point where the total first reaches a programmable level. The four results go to the outputs as separate fields and also as one packed word for a downstream serial link. A link of this kind adds a fixed 7-cycle delay, so the receiving logic has to align for it.

To let the data flow be inspected, the block writes every recorded sample set and its results into two circular spy buffers at one shared address. A freeze input stops recording. A synchronous read port with a one-cycle read latency returns either buffer by address, and the current write pointer is visible so the caller can find the newest entry.

Top module: `trig_peak_sum`

## Requirements
- R1: `peak_o` is the largest of the sixteen 10-bit samples. The sample set applied at clock edge k appears on the outputs after edge k+1.
- R2: `peak_ch_o` is the index of the channel holding the largest sample. Channel c sits at bits [10c+9:10c] of `samp_i`. When several channels share the largest value, including when all samples are zero, the lowest index is reported.
- R3: `sum_o` is the exact 14-bit sum of all sixteen samples. Full scale is 16368, so the sum never overflows.
- R4: A free-running count starts at 0 on the first edge after reset and tags each captured sample set. `over_o` shows that the sum of the set is at or above `thr_i`, where `thr_i` is sampled together with the set. When `over_o` rises, `ptime_o` takes the tag of that set.
- R5: `ptime_o` changes only when `over_o` rises. It holds while the sum stays at or above the threshold, and it also holds after the sum drops below it.
- R6: With `spy_sel_i`=0, the input spy entry n holds the n-th recorded sample set, in the same bit layout as `samp_i`.
- R7: With `spy_sel_i`=1, the output spy entry n holds the results of the n-th recorded set, zero-extended. The layout is peak in bits [9:0], channel index in bits [13:10], sum in bits [27:14] and pulse time in bits [43:28]. This matches `res_o`.
- R8: A sample set applied while `frz_i` is high is not recorded, and `spy_wptr_o` holds.
- R9: `spy_wptr_o` starts at 0, rises by one for each recorded set, and wraps after 1024 entries. When it wraps, newer entries overwrite the oldest ones.
- R10: Read data appears on `spy_rdata_o` one edge after the address. A read of the entry being written on the same edge returns the earlier content.
- R11: While reset is asserted, every result output, the read data and the write pointer are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_i | input | 160 | Sixteen 10-bit samples, channel c at bits [10c+9:10c] |
| thr_i | input | 14 | Sum threshold for the pulse-time stamp |
| frz_i | input | 1 | Do not record this sample set |
| peak_o | output | 10 | Largest amplitude |
| peak_ch_o | output | 4 | Channel of largest amplitude |
| sum_o | output | 14 | Sum of all amplitudes |
| ptime_o | output | 16 | Pulse-time stamp |
| over_o | output | 1 | Sum at or above threshold |
| res_o | output | 44 | Packed result word for the link |
| spy_sel_i | input | 1 | 0 selects the input spy, 1 selects the output spy |
| spy_addr_i | input | 10 | Spy read address |
| spy_rdata_o | output | 160 | Spy read data |
| spy_wptr_o | output | 10 | Next spy write address |

## Verification
A spy read and a spy write can hit the same entry on the same edge. The bench provokes this after the buffers have wrapped: it sets the read address to the current write pointer while a fresh set is being recorded there. It then expects the entry from the previous lap, taken from its own model before the new write is applied. Reads of older entries while frozen and after the wrap cover the ordinary path. The result stream runs through all of this, and its pattern set includes sums that sit exactly at the threshold and one count below it.

// File: rtl/trig_peak_sum.sv
module trig_peak_sum #(
  parameter int NCH = 16,
  parameter int DW  = 10,
  parameter int TW  = 16,
  parameter int AW  = 10,
  localparam int IW = $clog2(NCH),
  localparam int SW = DW + IW,
  localparam int VW = NCH * DW,
  localparam int RW = TW + SW + IW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] samp_i,
  input  logic [SW-1:0] thr_i,
  input  logic          frz_i,
  output logic [DW-1:0] peak_o,
  output logic [IW-1:0] peak_ch_o,
  output logic [SW-1:0] sum_o,
  output logic [TW-1:0] ptime_o,
  output logic          over_o,
  output logic [RW-1:0] res_o,
  input  logic          spy_sel_i,
  input  logic [AW-1:0] spy_addr_i,
  output logic [VW-1:0] spy_rdata_o,
  output logic [AW-1:0] spy_wptr_o
);
  localparam int DEPTH = 1 << AW;

  logic [VW-1:0] s_q;
  logic [SW-1:0] thr_q;
  logic          frz_q, v_q;
  logic [TW-1:0] cnt, tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q   <= '0;
      thr_q <= '0;
      frz_q <= 1'b0;
      v_q   <= 1'b0;
      cnt   <= '0;
      tag_q <= '0;
    end else begin
      s_q   <= samp_i;
      thr_q <= thr_i;
      frz_q <= frz_i;
      v_q   <= 1'b1;
      tag_q <= cnt;
      cnt   <= cnt + 1'b1;
    end
  end

  logic [DW-1:0] mx;
  logic [IW-1:0] mi;
  logic [SW-1:0] sm;

  always_comb begin
    mx = '0;
    mi = '0;
    sm = '0;
    for (int c = 0; c < NCH; c++) begin
      if (s_q[c*DW +: DW] > mx) begin
        mx = s_q[c*DW +: DW];
        mi = IW'(c);
      end
      sm = sm + SW'(s_q[c*DW +: DW]);
    end
  end

  wire           hit   = v_q && (sm >= thr_q);
  wire  [TW-1:0] pt_nx = (hit && !over_o) ? tag_q : ptime_o;
  wire           we    = v_q && !frz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_o     <= '0;
      peak_ch_o  <= '0;
      sum_o      <= '0;
      ptime_o    <= '0;
      over_o     <= 1'b0;
      spy_wptr_o <= '0;
    end else begin
      peak_o    <= mx;
      peak_ch_o <= mi;
      sum_o     <= sm;
      ptime_o   <= pt_nx;
      over_o    <= hit;
      if (we) spy_wptr_o <= spy_wptr_o + 1'b1;
    end
  end

  assign res_o = {ptime_o, sum_o, peak_ch_o, peak_o};

  logic [VW-1:0] in_mem  [DEPTH];
  logic [RW-1:0] out_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      in_mem[spy_wptr_o]  <= s_q;
      out_mem[spy_wptr_o] <= {pt_nx, sm, mi, mx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spy_rdata_o <= '0;
    else        spy_rdata_o <= spy_sel_i ? VW'(out_mem[spy_addr_i]) : in_mem[spy_addr_i];
  end
endmodule

module trig_peak_sum_chk #(
  parameter int NCH = 16,
  parameter int DW  = 10,
  parameter int IW  = 4,
  parameter int SW  = 14,
  parameter int TW  = 16,
  parameter int AW  = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frz_i,
  input logic [DW-1:0] peak_o,
  input logic [IW-1:0] peak_ch_o,
  input logic [SW-1:0] sum_o,
  input logic [TW-1:0] ptime_o,
  input logic          over_o,
  input logic [AW-1:0] spy_wptr_o
);
  logic [31:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1;
  end

  p_sum_vs_peak_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(peak_o) * NCH) >= int'(sum_o));

  p_zero_low_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_o == '0) |-> (peak_o == '0 && peak_ch_o == '0));

  p_stamp_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_o) |-> (ptime_o == TW'(cyc - 32'd2)));

  p_stamp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(over_o) |-> $stable(ptime_o));

  p_wptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (spy_wptr_o == $past(spy_wptr_o)) || (spy_wptr_o == AW'($past(spy_wptr_o) + 1'b1)));

  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frz_i, 2) |-> $stable(spy_wptr_o));
endmodule

bind trig_peak_sum trig_peak_sum_chk #(
  .NCH(NCH), .DW(DW), .IW(IW), .SW(SW), .TW(TW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frz_i(frz_i), .peak_o(peak_o), .peak_ch_o(peak_ch_o),
  .sum_o(sum_o), .ptime_o(ptime_o), .over_o(over_o), .spy_wptr_o(spy_wptr_o)
);

// File: tb/trig_peak_sum_bench.sv
module trig_peak_sum_bench;
  localparam int NCH = 16, DW = 10, IW = 4, SW = 14, TW = 16, AW = 10;
  localparam int VW = NCH * DW, RW = TW + SW + IW + DW;
  localparam int NJ = 1200;
  localparam int THR = 3000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [VW-1:0] samp_i = '0;
  logic [SW-1:0] thr_i = SW'(THR);
  logic          frz_i = 1'b0;
  logic          spy_sel_i = 1'b0;
  logic [AW-1:0] spy_addr_i = '0;
  logic [DW-1:0] peak_o;
  logic [IW-1:0] peak_ch_o;
  logic [SW-1:0] sum_o;
  logic [TW-1:0] ptime_o;
  logic          over_o;
  logic [RW-1:0] res_o;
  logic [VW-1:0] spy_rdata_o;
  logic [AW-1:0] spy_wptr_o;

  trig_peak_sum u_trig_peak_sum (
    .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .thr_i(thr_i), .frz_i(frz_i),
    .peak_o(peak_o), .peak_ch_o(peak_ch_o), .sum_o(sum_o), .ptime_o(ptime_o),
    .over_o(over_o), .res_o(res_o), .spy_sel_i(spy_sel_i), .spy_addr_i(spy_addr_i),
    .spy_rdata_o(spy_rdata_o), .spy_wptr_o(spy_wptr_o)
  );

  int errs = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] gen(input int j);
    logic [VW-1:0] v = '0;
    for (int c = 0; c < NCH; c++) begin
      logic [DW-1:0] a;
      case (j % 9)
        0: a = 0;
        1: a = (c == (j / 9) % NCH) ? 10'd1023 : 10'd0;
        2: a = (c == 3 || c == 9) ? 10'd700 : 10'd5;
        3: a = DW'(c * 60);
        4: a = 10'd1023;
        5: a = (c < 3) ? 10'd1000 : 10'd0;
        6: a = (c < 2) ? 10'd1000 : (c == 2) ? 10'd999 : 10'd0;
        7: a = DW'(((j * 37 + c * 101) ^ (c * 13)) & 1023);
        default: a = 10'd400;
      endcase
      v[c*DW +: DW] = a;
    end
    return v;
  endfunction

  logic [VW-1:0] rin  [1024];
  logic [RW-1:0] rout [1024];
  logic [VW-1:0] vh [NJ];
  logic [RW-1:0] oh [NJ];
  bit            fh [NJ];
  logic [RW:0]   sbq [$];

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int wc = 0;
    bit mo = 1'b0;
    logic [TW-1:0] mpt = '0;
    bit rd_pend = 1'b0;
    string rd_req = "";
    logic [VW-1:0] rd_exp = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk({peak_o, peak_ch_o, sum_o, ptime_o, over_o} == '0, "R11 results in reset",
        VW'({peak_o, peak_ch_o, sum_o, ptime_o, over_o}), '0);
    chk(spy_wptr_o == '0 && spy_rdata_o == '0, "R11 spy in reset", VW'({spy_wptr_o, spy_rdata_o}), '0);

    for (int j = 0; j < NJ; j++) begin
      if (j > 0) @(negedge clk);
      rst_n = 1'b1;

      if (sbq.size() >= 2) begin
        logic [RW:0] e = sbq.pop_front();
        chk(peak_o == e[DW-1:0], "R1 peak", VW'(peak_o), VW'(e[DW-1:0]));
        chk(peak_ch_o == e[DW +: IW], "R2 peak channel", VW'(peak_ch_o), VW'(e[DW +: IW]));
        chk(sum_o == e[DW+IW +: SW], "R3 sum", VW'(sum_o), VW'(e[DW+IW +: SW]));
        chk({over_o, ptime_o} == e[RW:RW-TW], "R4 R5 over and pulse time",
            VW'({over_o, ptime_o}), VW'(e[RW:RW-TW]));
        chk(res_o == e[RW-1:0], "R7 packed result word", VW'(res_o), VW'(e[RW-1:0]));
      end

      if (j >= 2 && !fh[j-2]) begin
        rin[wc % 1024]  = vh[j-2];
        rout[wc % 1024] = oh[j-2];
        wc++;
      end
      chk(spy_wptr_o == AW'(wc), (j >= 30 && j < 102) ? "R8 pointer under freeze" : "R9 write pointer",
          VW'(spy_wptr_o), VW'(wc));

      if (rd_pend) chk(spy_rdata_o == rd_exp, rd_req, spy_rdata_o, rd_exp);
      rd_pend = 1'b0;

      // new read request, expectation taken from the model before this edge's write
      spy_sel_i  = 1'b0;
      spy_addr_i = '0;
      if (j >= 85 && j < 100) begin
        spy_sel_i  = j[0];
        spy_addr_i = AW'((j - 85) * 3);
        rd_req     = j[0] ? "R7 output spy entry" : "R6 input spy entry";
        rd_pend    = 1'b1;
      end else if (j == 1150 || j == 1151) begin
        spy_sel_i  = (j == 1151);
        spy_addr_i = AW'(wc);
        rd_req     = "R10 read of entry written on same edge";
        rd_pend    = 1'b1;
      end else if (j == 1160) begin
        spy_sel_i  = 1'b0;
        spy_addr_i = AW'(5);
        rd_req     = "R9 entry after wrap";
        rd_pend    = 1'b1;
      end
      if (rd_pend)
        rd_exp = spy_sel_i ? VW'(rout[spy_addr_i]) : rin[spy_addr_i];

      // driver: new sample set and its expected results
      begin
        logic [VW-1:0] v = gen(j);
        logic [DW-1:0] m = '0;
        logic [IW-1:0] mc = '0;
        int s = 0;
        bit h;
        for (int c = 0; c < NCH; c++) begin
          if (v[c*DW +: DW] > m) begin m = v[c*DW +: DW]; mc = IW'(c); end
          s += int'(v[c*DW +: DW]);
        end
        h = (s >= THR);
        if (h && !mo) mpt = TW'(j);
        mo = h;
        vh[j] = v;
        fh[j] = (j >= 30 && j < 35) || (j >= 80 && j < 100);
        oh[j] = {mpt, SW'(s), mc, m};
        sbq.push_back({mo, oh[j]});
        samp_i = v;
        frz_i  = fh[j];
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule